// File: doc/BRIEF.md
# Prescaled Timer Counter with Compare-Reset

This block holds a 16-bit up-counter. The counter advances on ticks from a divider placed after the module clock. The divider divides by a power of two that is picked through a 3-bit code. The counter has two modes. In the first it runs freely and wraps, which raises a sticky overflow flag. In the second it returns to zero on the tick after it has reached the value on the channel-7 compare input. The compare value is then the last count of each period.

A small register bus writes three registers and reads them back. The channel mask register has one enable bit for each channel flag. The control register holds the overflow interrupt enable, the compare-reset enable and the divider code. The status register holds the overflow flag, which is cleared by writing one to it. The interrupt output combines the enabled overflow term with the eight channel flags, each gated by its mask bit. The channel flags come in from capture/compare logic outside this block.

The reset input is asynchronous and active low. Its release is expected to be synchronous to `clk`.

Top module: `pscl_timer`

## Requirements
- R1: While reset is asserted, and right after it, the count, overflow flag, interrupt and every register read as 0.
- R2: Control bits [2:0] hold the divider code. For codes 0 to 5 the count advances by one every 2^code clock cycles.
- R3: Codes 6 and 7 divide by 32.
- R4: Any write to the control register (address 1) restarts the divider. The first advance at the new rate comes exactly one period after the write edge, and the count holds before that.
- R5: With control bit 3 at 0, the compare value has no effect. The count runs to 0xFFFF, wraps to 0x0000 and sets the overflow flag (status address 2, bit 7).
- R6: With control bit 3 at 1, a tick that finds the count equal to the compare value loads 0 into the count.
- R7: With control bit 3 at 1 and a compare value of 0x0000, the count stays at 0x0000.
- R8: With control bit 3 at 1 and a compare value of 0xFFFF, the count goes from 0xFFFF to 0x0000 and the overflow flag is not set.
- R9: Writing address 2 with bit 7 at 1 clears the overflow flag. Writing bit 7 at 0 leaves the flag as it is. A wrap in the same cycle wins over the clear.
- R10: `irq` is high when the overflow flag and control bit 7 are both 1, or when some channel flag and its mask bit (address 0, same bit index) are both 1. It follows its inputs combinationally.
- R11: Reads are combinational. Address 0 returns the mask. Address 1 returns bit 7, bit 3 and bits [2:0] of the control register, and its bits 6..4 read 0. Address 2 returns the flag in bit 7. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cmp7_val | input | 16 | Channel-7 compare value |
| chan_flags | input | 8 | Channel capture/compare flags |
| count | output | 16 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Combined interrupt request |

## Verification
A register write takes effect on the edge that samples it. `bus_rdata` and `irq` follow in the same cycle, since both are combinational from registers and inputs. The count moves on the edge that has the tick. After a control write at edge E, with divide factor N, the next advance lands on edge E+N. A wrap changes the count and the overflow flag on the same edge. The bench drives inputs 2 ns after the falling edge and checks after that point. A cycle model in the bench, updated at every rising edge, gives the expected value for each falling-edge check. Directed checks count edges one at a time after each write.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 8;
  localparam int PSEL_W    = 3;
  localparam int MAX_SHIFT = 5;

  localparam logic [ADDR_W-1:0] A_CHMASK = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT   = 2'd2;

  localparam int B_OVF_IE   = 7;
  localparam int B_CNT_CLR  = 3;
  localparam int B_STAT_OVF = 7;

  typedef struct packed {
    logic              ovf_ie;
    logic              cnt_clr;
    logic [PSEL_W-1:0] psel;
  } ctrl_t;
endpackage

// File: rtl/pscl_div.sv
module pscl_div #(
  parameter int PSEL_W    = 3,
  parameter int MAX_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam int DW = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

  logic [DW-1:0]     cnt_q, cnt_d;
  logic [PSEL_W-1:0] shift;
  logic [DW:0]       span;
  logic [DW-1:0]     mask;

  // Codes beyond the largest stage use the slowest rate.
  always_comb begin
    if (int'(psel) > MAX_SHIFT) shift = PSEL_W'(MAX_SHIFT);
    else                        shift = psel;
    span = (DW+1)'(1) << shift;
    mask = DW'(span - 1'b1);
  end

  assign tick = ((cnt_q & mask) == mask);

  always_comb begin
    if (restart) cnt_d = '0;
    else         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pscl_cnt.sv
module pscl_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr_en,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit;

  assign hit = clr_en && (cnt_q == cmp_val);

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (tick) begin
      if (hit) begin
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        wrap  = &cnt_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/pscl_regs.sv
module pscl_regs
  import pscl_timer_pkg::*;
#(
  parameter int CH_N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              ovf_set,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CH_N-1:0]   ch_mask,
  output ctrl_t             ctrl,
  output logic              ovf_flag,
  output logic              ctrl_wr
);
  logic            mask_we, stat_we;
  logic [CH_N-1:0] mask_q, mask_d;
  ctrl_t           ctrl_q, ctrl_d;
  logic            ovf_q, ovf_d;

  assign mask_we = bus_wr && (bus_addr == A_CHMASK);
  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign stat_we = bus_wr && (bus_addr == A_STAT);

  always_comb begin
    mask_d = bus_wdata[CH_N-1:0];
    ctrl_d = '{ovf_ie:  bus_wdata[B_OVF_IE],
               cnt_clr: bus_wdata[B_CNT_CLR],
               psel:    bus_wdata[PSEL_W-1:0]};
    ovf_d  = ovf_q;
    if (ovf_set)                              ovf_d = 1'b1;
    else if (stat_we && bus_wdata[B_STAT_OVF]) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ctrl_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_d;
      if (ctrl_wr) ctrl_q <= ctrl_d;
      ovf_q <= ovf_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CHMASK: bus_rdata[CH_N-1:0] = mask_q;
      A_CTRL: begin
        bus_rdata[B_OVF_IE]     = ctrl_q.ovf_ie;
        bus_rdata[B_CNT_CLR]    = ctrl_q.cnt_clr;
        bus_rdata[PSEL_W-1:0]   = ctrl_q.psel;
      end
      A_STAT:   bus_rdata[B_STAT_OVF] = ovf_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign ch_mask  = mask_q;
  assign ctrl     = ctrl_q;
  assign ovf_flag = ovf_q;
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import pscl_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CH_N  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cmp7_val,
  input  logic [CH_N-1:0]   chan_flags,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_flag,
  output logic              irq
);
  ctrl_t           ctrl;
  logic            ctrl_wr, tick, wrap;
  logic            cnt_clr_en, ovf_ie;
  logic [CH_N-1:0] ch_mask, ch_term;

  pscl_regs #(.CH_N(CH_N)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ovf_set(wrap), .bus_rdata(bus_rdata),
    .ch_mask(ch_mask), .ctrl(ctrl), .ovf_flag(ovf_flag), .ctrl_wr(ctrl_wr)
  );

  assign cnt_clr_en = ctrl.cnt_clr;
  assign ovf_ie     = ctrl.ovf_ie;

  pscl_div #(.PSEL_W(PSEL_W), .MAX_SHIFT(MAX_SHIFT)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .psel(ctrl.psel), .tick(tick)
  );

  pscl_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr_en(cnt_clr_en),
    .cmp_val(cmp7_val), .count(count), .wrap(wrap)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_chan
    assign ch_term[g] = chan_flags[g] & ch_mask[g];
  end

  assign irq = (ovf_flag & ovf_ie) | (|ch_term);
endmodule

// File: rtl/pscl_timer_chk.sv
module pscl_timer_chk
  import pscl_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CH_N  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CNT_W-1:0]  cmp7_val,
  input logic [CH_N-1:0]   chan_flags,
  input logic [CNT_W-1:0]  count,
  input logic              ovf_flag,
  input logic              irq,
  input logic              cnt_clr_en,
  input logic              ovf_ie,
  input logic [CH_N-1:0]   ch_mask,
  input logic              wrap
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == $past(count) + 1'b1) || (count == '0))); // R2
  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && bus_wdata[PSEL_W-1:0] != '0) |-> ##2 $stable(count)); // R4
  AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (count == '0 && $past(count) == '1)); // R5
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr_en && cmp7_val == '0 && count == '0) |=> (count == '0)); // R7
  AST_NO_OVF_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clr_en && cmp7_val == '1 && count == '1 && !ovf_flag) |=> !ovf_flag); // R8
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STAT && bus_wdata[B_STAT_OVF] && !wrap) |=> !ovf_flag); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ovf_flag && ovf_ie) && ((chan_flags & ch_mask) == '0)) |-> !irq); // R10
endmodule

bind pscl_timer pscl_timer_chk #(.CNT_W(CNT_W), .CH_N(CH_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cmp7_val(cmp7_val), .chan_flags(chan_flags),
  .count(count), .ovf_flag(ovf_flag), .irq(irq), .cnt_clr_en(cnt_clr_en),
  .ovf_ie(ovf_ie), .ch_mask(ch_mask), .wrap(wrap)
);

// File: tb/pscl_timer_test.sv
module pscl_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] cmp7_val = '0;
  logic [7:0]  chan_flags = '0;
  logic [15:0] count;
  logic        ovf_flag, irq;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  // Reference state
  logic [7:0]  m_mask, m_ctrl;
  logic [4:0]  m_div;
  logic [15:0] m_cnt;
  logic        m_ovf;

  always #10 clk = ~clk;

  pscl_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp7_val(cmp7_val),
    .chan_flags(chan_flags), .count(count), .ovf_flag(ovf_flag), .irq(irq)
  );

  function automatic int period(input logic [2:0] code);
    return (code > 3'd5) ? 32 : (1 << code);
  endfunction

  function automatic logic exp_irq();
    return (m_ovf && m_ctrl[7]) || ((chan_flags & m_mask) != 8'h00);
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return m_mask;
      2'd1:    return m_ctrl & 8'h8F;
      2'd2:    return {m_ovf, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '0; m_ctrl = '0; m_div = '0; m_cnt = '0; m_ovf = 1'b0;
    end else begin
      logic tk, wr_flag;
      tk = ((int'(m_div) % period(m_ctrl[2:0])) == period(m_ctrl[2:0]) - 1);
      wr_flag = 1'b0;
      if (tk) begin
        if (m_ctrl[3] && m_cnt == cmp7_val) m_cnt = 16'h0000;
        else begin
          wr_flag = (m_cnt == 16'hFFFF);
          m_cnt = m_cnt + 16'd1;
        end
      end
      if (wr_flag) m_ovf = 1'b1;
      else if (bus_wr && bus_addr == 2'd2 && bus_wdata[7]) m_ovf = 1'b0;
      if (bus_wr && bus_addr == 2'd1) begin m_ctrl = bus_wdata; m_div = '0; end
      else m_div = m_div + 5'd1;
      if (bus_wr && bus_addr == 2'd0) m_mask = bus_wdata;
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && mon_en && !done) begin
      chk("R2", "count vs model", count, m_cnt);
      chk("R9", "ovf vs model", 16'(ovf_flag), 16'(m_ovf));
      chk("R10", "irq vs model", 16'(irq), 16'(exp_irq()));
      chk("R11", "rdata vs model", 16'(bus_rdata), 16'(exp_rdata(bus_addr)));
    end
  end

  task automatic step();
    @(negedge clk); #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic wait_count(input logic [15:0] v, input int limit);
    for (int i = 0; i < limit && count != v; i++) step();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL all: watchdog expired, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] c0;
    void'($urandom(32'd20240611));
    // R1: reset state
    chan_flags = 8'hFF;
    repeat (3) step();
    chk("R1", "count in reset", count, 16'h0000);
    chk("R1", "ovf in reset", 16'(ovf_flag), 16'h0);
    chk("R1", "irq in reset", 16'(irq), 16'h0);
    for (int a = 0; a < 4; a++) begin
      bus_addr = 2'(a); #1;
      chk("R1", "rdata in reset", 16'(bus_rdata), 16'h0000);
    end
    rst_n = 1'b1;
    mon_en = 1'b1;
    step();
    chk("R1", "count after release", count, 16'h0001);
    chan_flags = 8'h00;

    // R10: channel masking
    wr(2'd0, 8'h24);
    chan_flags = 8'h01; #1; chk("R10", "unmasked chan irq", 16'(irq), 16'h0);
    chan_flags = 8'h04; #1; chk("R10", "masked chan irq", 16'(irq), 16'h1);
    chan_flags = 8'hDB; #1; chk("R10", "complement chans irq", 16'(irq), 16'h0);
    chan_flags = 8'h20; #1; chk("R10", "chan5 irq", 16'(irq), 16'h1);
    chan_flags = 8'h00;

    // R11: readback
    wr(2'd1, 8'hFF);
    bus_addr = 2'd1; #1; chk("R11", "ctrl readback", 16'(bus_rdata), 16'h008F);
    bus_addr = 2'd0; #1; chk("R11", "mask readback", 16'(bus_rdata), 16'h0024);
    bus_addr = 2'd3; #1; chk("R11", "addr3 reads zero", 16'(bus_rdata), 16'h0000);

    // R6: compare-reset
    wr(2'd1, 8'h08);
    c0 = count;
    cmp7_val = c0 + 16'd4;
    wait_count(cmp7_val, 20);
    chk("R6", "reached compare", count, cmp7_val);
    step();
    chk("R6", "cleared after compare", count, 16'h0000);
    // R7: compare value zero holds
    cmp7_val = 16'h0000;
    for (int i = 0; i < 40; i++) begin
      step();
      chk("R7", "hold at zero", count, 16'h0000);
    end

    // R2/R3/R4: divider rates and restart
    for (int code = 0; code < 8; code++) begin
      int n;
      n = period(3'(code));
      wr(2'd1, 8'(code));
      c0 = count;
      for (int k = 1; k <= n; k++) begin
        step();
        if (k < n) chk("R4", "hold before first advance", count, c0);
        else if (code > 5) chk("R3", "reserved code divides by 32", count, c0 + 16'd1);
        else chk("R2", "advance after one period", count, c0 + 16'd1);
      end
    end

    // R5: free run wrap, compare ignored
    cmp7_val = 16'h0003;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h80);
    wait_count(16'hFFFF, 70000);
    chk("R5", "reached top", count, 16'hFFFF);
    chk("R5", "no flag before wrap", 16'(ovf_flag), 16'h0);
    step();
    chk("R5", "wrapped", count, 16'h0000);
    chk("R5", "flag on wrap", 16'(ovf_flag), 16'h1);
    chk("R10", "flag without enable", 16'(irq), 16'h0);
    wr(2'd1, 8'h80);
    chk("R10", "flag with enable", 16'(irq), 16'h1);
    // R9: clear behaviour
    wr(2'd2, 8'h7F);
    chk("R9", "write zero keeps flag", 16'(ovf_flag), 16'h1);
    wr(2'd2, 8'h80);
    chk("R9", "write one clears flag", 16'(ovf_flag), 16'h0);
    chk("R10", "irq drops with flag", 16'(irq), 16'h0);

    // R8: compare at top suppresses overflow
    cmp7_val = 16'hFFFF;
    wr(2'd1, 8'h88);
    wait_count(16'hFFFF, 70000);
    chk("R8", "reached top", count, 16'hFFFF);
    step();
    chk("R8", "cleared at top", count, 16'h0000);
    chk("R8", "no overflow flag", 16'(ovf_flag), 16'h0);

    // Random phase, checked by the per-cycle model
    for (int i = 0; i < 3000; i++) begin
      step();
      bus_wr = 1'b0;
      chan_flags = 8'($urandom);
      bus_addr = 2'($urandom);
      case ($urandom % 4)
        0: cmp7_val = 16'h0000;
        1: cmp7_val = 16'hFFFF;
        2: cmp7_val = 16'($urandom);
        default: cmp7_val = count + 16'($urandom % 8);
      endcase
      if (($urandom % 8) == 0) begin
        bus_wr = 1'b1;
        bus_wdata = 8'($urandom);
        if (bus_addr == 2'd1 && ($urandom % 2) == 0) bus_wdata[2:0] = 3'($urandom % 3);
      end
    end
    step();
    bus_wr = 1'b0;
    step();
    finish_run();
  end
endmodule